// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block sits on the host side of a single-channel serial analog-to-digital converter. The converter uses a fixed sixteen-clock frame. A one-cycle start request, or a held one, makes the reader pull the active-low select line down, and that edge also starts the conversion. The reader then generates exactly sixteen serial clock cycles from the system clock, with a half-period set by a parameter. It shifts in all sixteen frame bits and raises select again. The serial clock rests high whenever select is high. After each frame, select stays high for a parameterized quiet interval before another read is accepted.

A frame carries four leading zeros, then the sample MSB first, then zero padding. The padding is zero, two or four bits long for 12-, 10- or 8-bit converters. The reader removes the padding and returns the sample right-aligned on a valid/ready output. It also returns a framing-error flag that is set when any leading bit was not zero. Bits are normally taken just before each falling serial-clock edge. A slow-clock mode takes the first leading zero at the first falling edge and every later bit at the rising edge that follows its launch. An abort input ends a frame early, and no sample is produced for that frame.

Back-pressure rules: once `smp_valid_o` is high, the word and flag hold steady until a cycle in which `smp_ready_i` is high, and valid drops after that cycle. While a word is waiting, start requests are ignored, so the converter is never read into a full output.

Top module: `sadc_reader`

## Requirements
- R1: A start request is taken only when the reader is idle (`busy_o` low) and no word is waiting. `cs_n_o` falls at the clock edge that samples it. Requests made while busy or while a word is waiting have no effect.
- R2: `sclk_o` is high whenever `cs_n_o` is high, and every completed frame contains exactly 16 falling edges of `sclk_o`.
- R3: `sclk_o` stays high for HALF_DIV system clocks after `cs_n_o` falls, then toggles every HALF_DIV clocks. A completed frame keeps `cs_n_o` low for 33*HALF_DIV clocks.
- R4: With `rise_cap_i` low at acceptance, the bit present on `sdata_i` before falling edge n (n = 1..16) is taken as frame bit n, with frame bit 1 being the MSB of the 16-bit frame.
- R5: With `rise_cap_i` high at acceptance, frame bit 1 is taken before the first falling edge and frame bit n (n = 2..16) at rising edge n-1. The result equals that of R4 for a converter that changes data on falling edges.
- R6: `res_sel_i` is latched at acceptance: code 0 = 12 bits, 1 = 10 bits, 2 = 8 bits, 3 behaves as 12 bits. The output word is frame bits 5..16 shifted right by 0, 2 or 4, so the sample is right-aligned with zeros above it.
- R7: `smp_ferr_o` is high with a word exactly when any of the four leading frame bits was 1. The data word is unaffected.
- R8: `abort_i` high during a frame raises `cs_n_o` and holds `sclk_o` high at the next edge, and no word is produced for that frame.
- R9: After every frame, completed or aborted, `cs_n_o` stays high for at least QUIET_CYC+1 system clocks before it can fall again.
- R10: The word appears with `smp_valid_o` at the edge where `cs_n_o` rises after a completed frame. It holds steady while `smp_ready_i` is low and drops after a cycle with `smp_ready_i` high.
- R11: After reset, `cs_n_o` and `sclk_o` are high and `busy_o` and `smp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Read request |
| abort_i | input | 1 | End the current frame early |
| res_sel_i | input | 2 | Converter resolution code |
| rise_cap_i | input | 1 | Capture on rising serial edges (slow clock mode) |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low select / conversion start |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | Frame or quiet interval in progress |
| smp_valid_o | output | 1 | Output word valid |
| smp_ready_i | input | 1 | Output word accepted |
| smp_data_o | output | FRAME_BITS-LEAD_BITS | Right-aligned sample |
| smp_ferr_o | output | 1 | A leading bit was not zero |

## Verification
Select falls at the edge that samples the start request. The first serial falling edge follows HALF_DIV clocks later. The word and valid appear at the same edge where select rises, 33*HALF_DIV clocks after it fell, and an abort shows on select and the clock one edge after it is sampled. The bench drives inputs on falling system-clock edges and counts falling edges from the one where select is first seen low. It looks at the serial clock exactly at counts HALF_DIV and HALF_DIV+1, and reads the word at the first falling edge where select is high again. Ready is held low for a random number of cycles to check that the word holds, and the quiet gap is measured in falling edges with select high.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_QUIET = 2'd2
  } sadc_st_e;

  localparam logic [1:0] RES_12 = 2'd0;
  localparam logic [1:0] RES_10 = 2'd1;
  localparam logic [1:0] RES_8  = 2'd2;

  // number of padding bits after the sample for a resolution code
  function automatic logic [2:0] pad_bits(input logic [1:0] code);
    case (code)
      RES_10:  pad_bits = 3'd2;
      RES_8:   pad_bits = 3'd4;
      default: pad_bits = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/sadc_tick.sv
module sadc_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R3: ticks are spaced by HALF_DIV clocks, so two never come back to back unless HALF_DIV is 1
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (HALF_DIV > 1 && tick) |=> !tick);

endmodule

// File: rtl/sadc_shift.sv
module sadc_shift #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  cap,
  input  logic                  din,
  output logic [FRAME_BITS-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (clr)  word <= '0;
    else if (cap)  word <= {word[FRAME_BITS-2:0], din};
  end

  // R4: a capture moves the previous low bit up by one place
  a_r4_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !clr) |=> word[1] == $past(word[0]));

endmodule

// File: rtl/sadc_outbuf.sv
module sadc_outbuf #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ferr_in,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         ferr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
      ferr  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
      ferr  <= ferr_in;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R10: a waiting word holds until it is taken
  a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout) && $stable(ferr)));

  // R10: a taken word leaves unless a new one is loaded
  a_r10_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> !valid);

endmodule

// File: rtl/sadc_reader.sv
module sadc_reader
  import sadc_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int QUIET_CYC  = 6,
  parameter int FRAME_BITS = 16,
  parameter int LEAD_BITS  = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic                             abort_i,
  input  logic [1:0]                       res_sel_i,
  input  logic                             rise_cap_i,
  input  logic                             sdata_i,
  output logic                             cs_n_o,
  output logic                             sclk_o,
  output logic                             busy_o,
  output logic                             smp_valid_o,
  input  logic                             smp_ready_i,
  output logic [FRAME_BITS-LEAD_BITS-1:0]  smp_data_o,
  output logic                             smp_ferr_o
);
  localparam int DATA_W = FRAME_BITS - LEAD_BITS;
  localparam int PH_W   = $clog2(2 * FRAME_BITS + 1);
  localparam int QW     = (QUIET_CYC > 1) ? $clog2(QUIET_CYC + 1) : 1;
  localparam logic [PH_W-1:0] PH_END   = PH_W'(2 * FRAME_BITS);
  localparam logic [PH_W-1:0] PH_RLAST = PH_W'(2 * FRAME_BITS - 3);
  localparam logic [QW-1:0]   Q_LAST   = QW'(QUIET_CYC - 1);

  sadc_st_e              st_q;
  logic [PH_W-1:0]       ph_q;
  logic                  cs_n_q, sclk_q, rise_q;
  logic [1:0]            res_q;
  logic [QW-1:0]         qcnt_q;

  logic                  tick, accept, finish, cap_now, fall_slot, rise_slot;
  logic [FRAME_BITS-1:0] word;
  logic [DATA_W-1:0]     aligned;
  logic                  lead_bad;

  assign accept    = (st_q == ST_IDLE) && start_i && !smp_valid_o;
  assign finish    = (st_q == ST_FRAME) && !abort_i && tick && (ph_q == PH_END);
  // phase ph -> ph+1 is a falling serial edge when ph is even
  assign fall_slot = !ph_q[0] && (ph_q != PH_END);
  assign rise_slot = (ph_q == '0) || (ph_q[0] && (ph_q <= PH_RLAST));
  assign cap_now   = (st_q == ST_FRAME) && !abort_i && tick &&
                     (rise_q ? rise_slot : fall_slot);

  sadc_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_q == ST_FRAME),
    .tick (tick)
  );

  sadc_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .cap  (cap_now),
    .din  (sdata_i),
    .word (word)
  );

  always_comb begin
    aligned  = word[DATA_W-1:0] >> pad_bits(res_q);
    lead_bad = |word[FRAME_BITS-1:DATA_W];
  end

  sadc_outbuf #(.W(DATA_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (finish),
    .din    (aligned),
    .ferr_in(lead_bad),
    .ready  (smp_ready_i),
    .valid  (smp_valid_o),
    .dout   (smp_data_o),
    .ferr   (smp_ferr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b1;
      rise_q <= 1'b0;
      res_q  <= RES_12;
      qcnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q   <= ST_FRAME;
            cs_n_q <= 1'b0;
            ph_q   <= '0;
            rise_q <= rise_cap_i;
            res_q  <= res_sel_i;
          end
        end
        ST_FRAME: begin
          if (abort_i) begin
            st_q   <= ST_QUIET;
            cs_n_q <= 1'b1;
            sclk_q <= 1'b1;
            qcnt_q <= '0;
          end else if (tick) begin
            if (ph_q == PH_END) begin
              st_q   <= ST_QUIET;
              cs_n_q <= 1'b1;
              qcnt_q <= '0;
            end else begin
              ph_q   <= ph_q + 1'b1;
              sclk_q <= ~sclk_q;
            end
          end
        end
        ST_QUIET: begin
          if (qcnt_q == Q_LAST) st_q <= ST_IDLE;
          else                  qcnt_q <= qcnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n_o = cs_n_q;
  assign sclk_o = sclk_q;
  assign busy_o = (st_q != ST_IDLE);

  // ---------------- checks ----------------
  logic            sclk_d;
  logic [PH_W-1:0] fall_cnt;
  logic [QW-1:0]   hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b1;
      fall_cnt <= '0;
      hi_cnt   <= QW'(QUIET_CYC);
    end else begin
      sclk_d <= sclk_o;
      if (accept)                fall_cnt <= '0;
      else if (sclk_d && !sclk_o) fall_cnt <= fall_cnt + 1'b1;
      if (!cs_n_o)                       hi_cnt <= '0;
      else if (hi_cnt != QW'(QUIET_CYC)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R2: the serial clock rests high while select is high
  a_r2_clk_idles_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  // R2: a delivered word follows exactly FRAME_BITS falling edges
  a_r2_sixteen_falls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid_o) |-> (fall_cnt == PH_W'(FRAME_BITS)));

  // R1: a blocked request leaves select high
  a_r1_blocked_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && (busy_o || smp_valid_o)) |=> cs_n_o);

  // R8: abort closes the frame at once without a word
  a_r8_abort_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FRAME && abort_i) |=> (cs_n_o && sclk_o && !smp_valid_o));

  // R9: select stays high for the quiet interval
  a_r9_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (hi_cnt >= QW'(QUIET_CYC)));

endmodule

// File: tb/sadc_reader_test.sv
module sadc_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int QUIET      = 6;
  localparam int FRAME_LOW  = 33 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, abort_i = 1'b0, rise_cap_i = 1'b0;
  logic [1:0]  res_sel_i = 2'd0;
  logic        sdata_i = 1'b1;
  logic        smp_ready_i = 1'b0;
  logic        cs_n_o, sclk_o, busy_o, smp_valid_o, smp_ferr_o;
  logic [11:0] smp_data_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sadc_reader #(.HALF_DIV(HALF), .QUIET_CYC(QUIET), .FRAME_BITS(16), .LEAD_BITS(4)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .res_sel_i(res_sel_i), .rise_cap_i(rise_cap_i), .sdata_i(sdata_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_o(busy_o),
    .smp_valid_o(smp_valid_o), .smp_ready_i(smp_ready_i),
    .smp_data_o(smp_data_o), .smp_ferr_o(smp_ferr_o));

  // converter model: first bit on select fall, later bits after each falling edge
  logic [15:0] fr = '0;
  int bidx = 0;
  int nfall = 0;
  always @(negedge cs_n_o) begin bidx = 0; #1 sdata_i = fr[15]; end
  always @(negedge sclk_o) if (!cs_n_o) begin
    nfall++;
    bidx++;
    #1 sdata_i = (bidx < 16) ? fr[15 - bidx] : 1'b1;
  end
  always @(posedge cs_n_o) begin #1 sdata_i = 1'b1; end

  // high-gap monitor in falling edges of clk
  int hi_run = 1000, last_hi = 1000;
  always @(negedge clk) begin
    if (cs_n_o) hi_run++;
    else begin
      if (hi_run > 0) last_hi = hi_run;
      hi_run = 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] code);
    return (code == 2'd1) ? 10 : (code == 2'd2) ? 8 : 12;
  endfunction

  function automatic logic [11:0] exp_word(input logic [11:0] v, input logic [1:0] code);
    return v & ((12'hFFF) >> (12 - width_of(code)));
  endfunction

  function automatic logic [15:0] build_frame(input logic [11:0] v, input logic [1:0] code,
                                              input logic [3:0] lead);
    int w = width_of(code);
    return {lead, 12'(exp_word(v, code) << (12 - w))};
  endfunction

  // one read; ab = 0 for a full frame, else abort at that low-cycle count
  task automatic do_read(input logic [11:0] v, input logic [1:0] code, input bit rise,
                         input logic [3:0] lead, input int ab, input int wait_rdy);
    int lowcyc;
    fr = build_frame(v, code, lead);
    res_sel_i = code;
    rise_cap_i = rise;
    while (busy_o || smp_valid_o) @(negedge clk);
    nfall = 0;
    start_i = 1'b1;
    @(negedge clk);
    chk(cs_n_o == 1'b0, "R1 select falls at accepting edge", cs_n_o, 0);
    chk(last_hi >= QUIET + 1, "R9 quiet gap", last_hi, QUIET + 1);
    start_i = 1'b0;
    res_sel_i = ~code;
    rise_cap_i = ~rise;
    lowcyc = 0;
    while (cs_n_o == 1'b0) begin
      lowcyc++;
      if (lowcyc == HALF)     chk(sclk_o == 1'b1, "R3 clock high before first fall", sclk_o, 1);
      if (lowcyc == HALF + 1) chk(sclk_o == 1'b0, "R3 first fall after half period", sclk_o, 0);
      if (lowcyc == 5) start_i = 1'b1;          // R1: ignored mid-frame
      if (lowcyc == 6) start_i = 1'b0;
      if (ab != 0 && lowcyc == ab) begin
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(cs_n_o == 1'b1 && sclk_o == 1'b1, "R8 abort raises select, clock high",
            {cs_n_o, sclk_o}, 3);
        chk(smp_valid_o == 1'b0, "R8 no word after abort", smp_valid_o, 0);
        repeat (QUIET + 3) @(negedge clk);
        chk(smp_valid_o == 1'b0, "R8 still no word", smp_valid_o, 0);
        return;
      end
      @(negedge clk);
    end
    chk(lowcyc == FRAME_LOW, "R3 select low time", lowcyc, FRAME_LOW);
    chk(nfall == 16, "R2 sixteen falling edges", nfall, 16);
    chk(smp_valid_o == 1'b1, "R10 word valid as select rises", smp_valid_o, 1);
    chk(smp_data_o == exp_word(v, code),
        rise ? "R5 rising capture word, R6 alignment" : "R4 falling capture word, R6 alignment",
        smp_data_o, exp_word(v, code));
    chk(smp_ferr_o == (lead != 4'd0), "R7 framing flag", smp_ferr_o, lead != 4'd0);
    for (int i = 0; i < wait_rdy; i++) begin
      if (i == 0) start_i = 1'b1;               // R1: ignored while word waits
      @(negedge clk);
      chk(smp_valid_o && smp_data_o == exp_word(v, code) && cs_n_o,
          "R10 word held, R1 start blocked", smp_data_o, exp_word(v, code));
    end
    start_i = 1'b0;
    smp_ready_i = 1'b1;
    @(negedge clk);
    smp_ready_i = 1'b0;
    chk(smp_valid_o == 1'b0, "R10 valid drops after take", smp_valid_o, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(cs_n_o == 1'b1 && sclk_o == 1'b1, "R11 reset select and clock", {cs_n_o, sclk_o}, 3);
    chk(busy_o == 1'b0 && smp_valid_o == 1'b0, "R11 reset busy and valid",
        {busy_o, smp_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n_o == 1'b1 && busy_o == 1'b0, "R11 idle after reset", {cs_n_o, busy_o}, 2);

    do_read(12'hFFF, 2'd0, 1'b0, 4'h0, 0, 0);
    do_read(12'h000, 2'd0, 1'b0, 4'h0, 0, 2);
    do_read(12'hA5C, 2'd0, 1'b1, 4'h0, 0, 1);
    do_read(12'h3FF, 2'd1, 1'b1, 4'h0, 0, 0);
    do_read(12'h281, 2'd1, 1'b0, 4'h0, 0, 0);
    do_read(12'h081, 2'd2, 1'b0, 4'h0, 0, 3);
    do_read(12'h0FE, 2'd2, 1'b1, 4'h0, 0, 0);
    do_read(12'h9C3, 2'd3, 1'b0, 4'h0, 0, 0);
    do_read(12'h555, 2'd0, 1'b0, 4'h8, 0, 0);
    do_read(12'h2AA, 2'd1, 1'b1, 4'h1, 0, 0);
    do_read(12'h123, 2'd0, 1'b0, 4'h0, 1, 0);
    do_read(12'h456, 2'd0, 1'b1, 4'h0, FRAME_LOW - 1, 0);
    do_read(12'h789, 2'd2, 1'b0, 4'h0, 17, 0);
    do_read(12'hBEE, 2'd0, 1'b0, 4'h0, 0, 0);

    for (int k = 0; k < 40; k++) begin
      logic [11:0] v  = 12'($urandom);
      logic [1:0]  c  = 2'($urandom);
      bit          r  = 1'($urandom);
      logic [3:0]  ld = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
      int          ab = (($urandom % 6) == 0) ? 1 + int'($urandom % (FRAME_LOW - 1)) : 0;
      do_read(v, c, r, ld, ab, int'($urandom % 4));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule